// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, given as a segment number and an offset, into a physical address. It uses a small segment table held in registers inside the block. Each table entry holds four things: the segment's starting physical address (its base), the segment's length (its limit), a valid bit, and three permission bits for read, write and execute.

For every request, the block runs four checks:
- the segment number is compared with a programmable segment-count register;
- the entry's valid bit is checked;
- the offset is compared with the entry's limit;
- the access kind is compared with the entry's permissions.

If all four checks pass, the result is the base plus the offset. If any check fails, the block raises a trap and reports a single cause code.

A write port loads one table entry, or the segment-count register, per cycle. Results are registered and appear one cycle after the request. Deciding where segments are placed in memory is left to software.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, every table entry is marked not valid, the segment-count register is 0, and all response outputs are 0. A lookup made straight after reset therefore traps with cause 1.
- R2: `rsp_valid` is high exactly one cycle after `req_valid` is high. In a cycle with no request, `rsp_trap`, `rsp_cause` and `rsp_paddr` are all 0 on the following cycle.
- R3: A request whose segment number is greater than or equal to the segment-count register traps with cause code 1.
- R4: A request to an in-range segment whose valid bit is 0 traps with cause code 2.
- R5: A request whose offset is greater than or equal to the entry's limit traps with cause code 3. A limit of 0 therefore rejects every offset.
- R6: The access kind is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. The permission field uses bit 0 = read, bit 1 = write and bit 2 = execute. A request traps with cause code 4 when the permission bit for its access kind is 0, and the reserved kind always traps with cause 4.
- R7: A request that passes every check returns `rsp_trap`=0, cause 0, and `rsp_paddr` = base + zero-extended offset, taken modulo 2^BASE_W.
- R8: When several checks fail, only the first in the order range, invalid, limit, permission is reported. Whenever `rsp_trap` is 1, `rsp_paddr` is 0.
- R9: A table or register write takes effect on the next cycle. A lookup issued in the same cycle as a write sees the old contents.
- R10: A write with `wr_len_sel`=1 loads `wr_len` into the segment-count register and leaves the table unchanged. With `wr_len_sel`=0, the write loads entry `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | SEG_W (4) | Segment number |
| req_off | input | OFF_W (16) | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| wr_en | input | 1 | Write strobe |
| wr_len_sel | input | 1 | 1 selects the segment-count register, 0 selects a table entry |
| wr_idx | input | SEG_W (4) | Index of the entry to write |
| wr_base | input | BASE_W (32) | Base to store |
| wr_limit | input | OFF_W+1 (17) | Limit (segment length) to store |
| wr_perm | input | 3 | Permissions to store: bit 0 read, bit 1 write, bit 2 execute |
| wr_vld | input | 1 | Valid bit to store |
| wr_len | input | SEG_W+1 (5) | New segment-count value |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_trap | output | 1 | The access was rejected |
| rsp_cause | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 permission |
| rsp_paddr | output | BASE_W (32) | Physical address, or 0 on a trap |

## Verification
The bench builds the block with its default parameters: 16 entries, a 16-bit offset and a 32-bit base.

These values put several corner cases within reach:
- The 17-bit limit makes a full 65536-byte segment possible, so an offset of 0xFFFF can pass the limit check.
- A base near the top of the 32-bit space makes the base-plus-offset sum wrap.
- The 5-bit segment-count register can hold values both below and above the table size.

A seeded pseudo-random phase mixes writes and lookups, including same-cycle write-and-lookup collisions, against an independent table model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_RANGE   = 3'd1,
      CAUSE_INVALID = 3'd2,
      CAUSE_LIMIT   = 3'd3,
      CAUSE_PERM    = 3'd4
   } cause_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int NUM_SEGS = 16,
   parameter int BASE_W   = 32,
   parameter int LIM_W    = 17,
   parameter int SEG_W    = $clog2(NUM_SEGS),
   parameter int LEN_W    = SEG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_len_sel,
   input  logic [SEG_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [LIM_W-1:0]  wr_limit,
   input  logic [2:0]        wr_perm,
   input  logic              wr_vld,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [SEG_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_limit,
   output logic [2:0]        rd_perm,
   output logic              rd_vld,
   output logic [LEN_W-1:0]  len_q
);

   logic [BASE_W-1:0] base_a  [NUM_SEGS];
   logic [LIM_W-1:0]  limit_a [NUM_SEGS];
   logic [2:0]        perm_a  [NUM_SEGS];
   logic              vld_a   [NUM_SEGS];

   for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
      logic [BASE_W-1:0] base_r;
      logic [LIM_W-1:0]  limit_r;
      logic [2:0]        perm_r;
      logic              vld_r;
      logic              hit;

      assign hit = wr_en && !wr_len_sel && (wr_idx == SEG_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_r  <= '0;
            limit_r <= '0;
            perm_r  <= '0;
            vld_r   <= 1'b0;
         end else if (hit) begin
            base_r  <= wr_base;
            limit_r <= wr_limit;
            perm_r  <= wr_perm;
            vld_r   <= wr_vld;
         end
      end

      assign base_a[g]  = base_r;
      assign limit_a[g] = limit_r;
      assign perm_a[g]  = perm_r;
      assign vld_a[g]   = vld_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  len_q <= '0;
      else if (wr_en && wr_len_sel) len_q <= wr_len;
   end

   assign rd_base  = base_a[rd_idx];
   assign rd_limit = limit_a[rd_idx];
   assign rd_perm  = perm_a[rd_idx];
   assign rd_vld   = vld_a[rd_idx];

   // R10
   len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_len_sel) |=> (len_q == $past(wr_len)));

   // R10
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_len_sel) |=> $stable(len_q));

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W  = 4,
   parameter int OFF_W  = 16,
   parameter int BASE_W = 32,
   parameter int LIM_W  = OFF_W + 1,
   parameter int LEN_W  = SEG_W + 1
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        acc,
   input  logic [LEN_W-1:0]  seg_len,
   input  logic [BASE_W-1:0] base,
   input  logic [LIM_W-1:0]  limit,
   input  logic [2:0]        perm,
   input  logic              ent_vld,
   output cause_e            cause,
   output logic [BASE_W-1:0] sum
);

   logic [BASE_W-1:0] off_ext;
   logic              range_bad, lim_bad, perm_ok;

   if (OFF_W < BASE_W) begin : g_zext
      assign off_ext = {{(BASE_W-OFF_W){1'b0}}, off};
   end else begin : g_same
      assign off_ext = off;
   end

   assign range_bad = ({1'b0, seg} >= seg_len);
   assign lim_bad   = ({1'b0, off} >= limit);

   always_comb begin
      unique case (acc_e'(acc))
         ACC_READ:  perm_ok = perm[PERM_RD];
         ACC_WRITE: perm_ok = perm[PERM_WR];
         ACC_EXEC:  perm_ok = perm[PERM_EX];
         default:   perm_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (range_bad)     cause = CAUSE_RANGE;
      else if (!ent_vld) cause = CAUSE_INVALID;
      else if (lim_bad)  cause = CAUSE_LIMIT;
      else if (!perm_ok) cause = CAUSE_PERM;
      else               cause = CAUSE_NONE;
   end

   assign sum = base + off_ext;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEGS = 16,
   parameter int OFF_W    = 16,
   parameter int BASE_W   = 32,
   localparam int SEG_W   = $clog2(NUM_SEGS),
   localparam int LEN_W   = SEG_W + 1,
   localparam int LIM_W   = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_acc,
   input  logic              wr_en,
   input  logic              wr_len_sel,
   input  logic [SEG_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [LIM_W-1:0]  wr_limit,
   input  logic [2:0]        wr_perm,
   input  logic              wr_vld,
   input  logic [LEN_W-1:0]  wr_len,
   output logic              rsp_valid,
   output logic              rsp_trap,
   output logic [2:0]        rsp_cause,
   output logic [BASE_W-1:0] rsp_paddr
);

   if (NUM_SEGS < 2 || (NUM_SEGS & (NUM_SEGS - 1)) != 0) begin : g_bad_segs
      $error("NUM_SEGS must be a power of two of at least 2");
   end
   if (OFF_W < 1 || OFF_W > BASE_W) begin : g_bad_off
      $error("OFF_W must lie in 1..BASE_W");
   end

   logic [BASE_W-1:0] ent_base, sum;
   logic [LIM_W-1:0]  ent_limit;
   logic [2:0]        ent_perm;
   logic              ent_vld;
   logic [LEN_W-1:0]  seg_len;
   cause_e            cause_c;

   seg_table #(
      .NUM_SEGS(NUM_SEGS), .BASE_W(BASE_W), .LIM_W(LIM_W),
      .SEG_W(SEG_W), .LEN_W(LEN_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_len_sel(wr_len_sel), .wr_idx(wr_idx),
      .wr_base(wr_base), .wr_limit(wr_limit), .wr_perm(wr_perm),
      .wr_vld(wr_vld), .wr_len(wr_len),
      .rd_idx(req_seg),
      .rd_base(ent_base), .rd_limit(ent_limit), .rd_perm(ent_perm),
      .rd_vld(ent_vld), .len_q(seg_len)
   );

   seg_check #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W),
      .LIM_W(LIM_W), .LEN_W(LEN_W)
   ) u_check (
      .seg(req_seg), .off(req_off), .acc(req_acc), .seg_len(seg_len),
      .base(ent_base), .limit(ent_limit), .perm(ent_perm), .ent_vld(ent_vld),
      .cause(cause_c), .sum(sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_trap  <= 1'b0;
         rsp_cause <= CAUSE_NONE;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_trap  <= (cause_c != CAUSE_NONE);
            rsp_cause <= cause_c;
            rsp_paddr <= (cause_c == CAUSE_NONE) ? sum : '0;
         end else begin
            rsp_trap  <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_paddr <= '0;
         end
      end
   end

   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_trap && rsp_paddr == '0));

   // R8
   trap_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_paddr == '0 && rsp_valid && rsp_cause != CAUSE_NONE));

   // R3
   seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ({1'b0, req_seg} >= seg_len)) |=> (rsp_cause == CAUSE_RANGE));

   // R4
   ent_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ({1'b0, req_seg} < seg_len) && !ent_vld)
      |=> (rsp_cause == CAUSE_INVALID));

   // R5
   off_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ({1'b0, req_seg} < seg_len) && ent_vld && ({1'b0, req_off} >= ent_limit))
      |=> (rsp_cause == CAUSE_LIMIT));

endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_seg = '0;
   logic [15:0] req_off = '0;
   logic [1:0]  req_acc = '0;
   logic        wr_en = 1'b0;
   logic        wr_len_sel = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_base = '0;
   logic [16:0] wr_limit = '0;
   logic [2:0]  wr_perm = '0;
   logic        wr_vld = 1'b0;
   logic [4:0]  wr_len = '0;
   logic        rsp_valid, rsp_trap;
   logic [2:0]  rsp_cause;
   logic [31:0] rsp_paddr;

   seg_xlate_unit uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
      .wr_en(wr_en), .wr_len_sel(wr_len_sel), .wr_idx(wr_idx), .wr_base(wr_base),
      .wr_limit(wr_limit), .wr_perm(wr_perm), .wr_vld(wr_vld), .wr_len(wr_len),
      .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
      .rsp_paddr(rsp_paddr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          cyc;
      logic        vld;
      logic [2:0]  cause;
      logic [31:0] pa;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0, n_bad = 0, cyc_n = 0;
   logic [31:0] m_base [16];
   logic [16:0] m_lim  [16];
   logic [2:0]  m_perm [16];
   logic        m_vld  [16];
   logic [4:0]  m_len;
   logic [31:0] seed = 32'h1234_5678;

   always @(posedge clk) if (rst_n) cyc_n <= cyc_n + 1;

   task automatic report;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].cyc < cyc_n) begin
         exp_t e;
         e = sb.pop_front();
         n_chk++;
         if (rsp_valid !== e.vld || rsp_trap !== (e.cause != 0) ||
             rsp_cause !== e.cause || rsp_paddr !== e.pa) begin
            n_bad++;
            $display("FAIL %s: got v=%b t=%b c=%0d pa=%h, expected v=%b t=%b c=%0d pa=%h",
                     e.tag, rsp_valid, rsp_trap, rsp_cause, rsp_paddr,
                     e.vld, (e.cause != 0), e.cause, e.pa);
         end
      end
   end

   function automatic logic [2:0] ref_cause(logic [3:0] s, logic [15:0] o, logic [1:0] a);
      if ({1'b0, s} >= m_len)            return 3'd1;
      if (!m_vld[s])                     return 3'd2;
      if ({1'b0, o} >= m_lim[s])         return 3'd3;
      if (a == 2'd3 || !m_perm[s][a])    return 3'd4;
      return 3'd0;
   endfunction

   task automatic go(string tag);
      exp_t e;
      e.cyc = cyc_n;
      e.vld = req_valid;
      e.tag = tag;
      e.cause = req_valid ? ref_cause(req_seg, req_off, req_acc) : 3'd0;
      e.pa = (req_valid && e.cause == 0) ? m_base[req_seg] + {16'h0, req_off} : 32'h0;
      sb.push_back(e);
      if (wr_en) begin
         if (wr_len_sel) m_len = wr_len;
         else begin
            m_base[wr_idx] = wr_base; m_lim[wr_idx] = wr_limit;
            m_perm[wr_idx] = wr_perm; m_vld[wr_idx] = wr_vld;
         end
      end
      @(negedge clk);
      req_valid = 1'b0;
      wr_en = 1'b0;
   endtask

   task automatic set_ent(logic [3:0] i, logic [31:0] b, logic [16:0] l, logic [2:0] p, logic v);
      wr_en = 1'b1; wr_len_sel = 1'b0; wr_idx = i;
      wr_base = b; wr_limit = l; wr_perm = p; wr_vld = v;
   endtask

   task automatic set_len(logic [4:0] n);
      wr_en = 1'b1; wr_len_sel = 1'b1; wr_len = n;
   endtask

   task automatic set_req(logic [3:0] s, logic [15:0] o, logic [1:0] a);
      req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
   endtask

   task automatic look(logic [3:0] s, logic [15:0] o, logic [1:0] a, string tag);
      set_req(s, o, a);
      go(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      report();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0; m_vld[i] = 1'b0;
      end
      m_len = '0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0 || rsp_trap !== 1'b0 || rsp_cause !== 3'd0 || rsp_paddr !== 32'h0) begin
         n_bad++;
         $display("FAIL R1: got v=%b t=%b c=%0d pa=%h, expected all zero",
                  rsp_valid, rsp_trap, rsp_cause, rsp_paddr);
      end
      rst_n = 1'b1;
      @(negedge clk);

      look(4'd0, 16'h0, 2'd0, "R1 lookup after reset");
      // R9: length and entry writes issued together with a lookup see old state
      set_len(5'd3); look(4'd0, 16'h10, 2'd0, "R9 same-cycle length write");
      set_ent(4'd0, 32'h1000_0000, 17'h100, 3'b011, 1'b1);
      look(4'd0, 16'h10, 2'd0, "R9 same-cycle entry write");
      look(4'd0, 16'h10, 2'd0, "R7 read hit");
      look(4'd0, 16'hFF, 2'd1, "R7 write at last byte");
      look(4'd0, 16'h100, 2'd0, "R5 offset equals limit");
      look(4'd0, 16'h4, 2'd2, "R6 exec denied");
      look(4'd0, 16'h4, 2'd3, "R6 reserved kind");
      set_ent(4'd1, 32'hFFFF_FF00, 17'h10000, 3'b100, 1'b1); go("R2 idle during write");
      look(4'd1, 16'h200, 2'd2, "R7 wraparound sum");
      look(4'd1, 16'hFFFF, 2'd2, "R7 full-size segment");
      look(4'd1, 16'h0, 2'd0, "R6 read denied");
      set_ent(4'd2, 32'h5000, 17'h20, 3'b111, 1'b0); go("R2 idle");
      look(4'd2, 16'h0, 2'd0, "R4 invalid entry");
      look(4'd2, 16'hFFFF, 2'd3, "R8 invalid over limit and perm");
      set_ent(4'd3, 32'h20, 17'h0, 3'b111, 1'b1); go("R10 entry beyond count");
      look(4'd3, 16'h0, 2'd0, "R3 segment equals count");
      look(4'd15, 16'hFFFF, 2'd3, "R8 range over all other faults");
      set_len(5'd4); go("R10 length write");
      look(4'd3, 16'h0, 2'd0, "R5 zero limit");
      look(4'd0, 16'h8, 2'd1, "R10 table kept across length write");
      set_len(5'd31); go("R10 large count");
      look(4'd15, 16'h0, 2'd0, "R4 top entry invalid");
      set_ent(4'd0, 32'hABCD_0000, 17'h100, 3'b001, 1'b1);
      look(4'd0, 16'h1, 2'd1, "R9 old perms still apply");
      look(4'd0, 16'h1, 2'd1, "R6 new perms apply");
      look(4'd0, 16'h1, 2'd0, "R7 new base");
      go("R2 no request");

      for (int k = 0; k < 400; k++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         if (seed[31:29] == 3'd0) set_len({1'b0, seed[20:17]} + 5'(seed[5]));
         else if (seed[31:29] < 3'd3)
            set_ent(seed[11:8], {seed[27:12], seed[15:0]}, {seed[6], seed[15:0]} >> seed[3:0],
                    seed[24:22], seed[21] | seed[20]);
         seed = seed * 32'd1103515245 + 32'd12345;
         if (seed[31:30] != 2'd0)
            set_req(seed[27:24], seed[17:2] >> seed[21:18], seed[23:22]);
         go("R8 random mix");
      end

      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      report();
   end

endmodule